// File: doc/BRIEF.md
# Quarter-Scale Inverse DCT

This block turns one 8x8 block of quantized transform coefficients into a 4x4 block of 8-bit pixels. It is meant for decoding an image at one quarter of its linear size. Each coefficient arrives together with its quantizer step. The block multiplies the two to recover the coefficient, then runs two separable one-dimensional transforms on the result. The first pass works down columns and the second works across rows. Both passes drop transform index 4, so each pass reads only seven of the eight positions in a line and produces four values.

Both passes use constants with 13 fractional bits and accumulate at 32 bits. The first pass descales by a rounding shift of 12 and the second by a rounding shift of 19. Each pass keeps the low 16 bits of its result. The final stage adds a level shift of 128 and clamps the pixel to 0..255.

The input is a valid/ready stream of 64 beats per block. The output presents one row of four pixels per cycle, with a valid strobe, over four consecutive cycles. The block accepts no input while it computes. It takes the next block in the same cycle that the last output row appears.

Top module: `idct4_quarter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. While `in_ready` is 0, activity on `in_valid`, `in_coef` and `in_qnt` has no effect on any result.
- R2: A block is 64 accepted beats, with beat number 8*row+col (row-major order). The coefficient used is the low 16 bits of the signed product `in_coef`*`in_qnt`, read as a signed 16-bit value.
- R3: Beats whose row or column is 4 are accepted but have no effect on any output pixel.
- R4: The column pass forms two even terms and two odd terms from inputs x0..x7 of a column, skipping x4. The even terms are x0*16384 ± (15137*x2 − 6270*x6). The first odd term is 20995*x1 + 7373*x3 − 4926*x5 − 4176*x7. The second odd term is 8697*x1 − 17799*x3 + 11893*x5 − 1730*x7. All arithmetic wraps at 32 bits. Each sum is rounded as (s + 2^11) >> 12, arithmetic, then truncated to 16 bits.
- R5: The row pass uses the same formulas on each row of column-pass results, skipping position 4. It rounds as (s + 2^18) >> 19, arithmetic, then truncates to 16 bits.
- R6: Output positions 0..3 of a pass are, in order: the plus-even term plus the first odd term, the minus-even term plus the second odd term, the minus-even term minus the second odd term, and the plus-even term minus the first odd term.
- R7: Each pixel is the 16-bit row-pass value plus 128, wrapped at 16 bits, then clamped to the range 0..255.
- R8: Output row r (r = 0..3) appears with `out_valid`=1 and `out_row`=r exactly 8+r cycles after the clock edge that accepts beat 63. Pixel column j is carried in `out_pix[8j+7:8j]`. `out_valid` is 0 in all other cycles.
- R9: `in_ready` is 0 from the edge that accepts beat 63 until output row 3 appears. It is 1 again in the same cycle as output row 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient beat offered |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_coef | input | 16 | Signed quantized coefficient |
| in_qnt | input | 16 | Signed quantizer step for the same position |
| out_valid | output | 1 | An output row is presented |
| out_row | output | 2 | Index of the presented row |
| out_pix | output | 32 | Four 8-bit pixels, column j at bits 8j+7..8j |

## Verification
The edge that accepts beat 63 sets the timing for a whole block. Output row r is due on exactly the (8+r)-th edge after it, and `in_ready` must fall with that edge and rise again with row 3. The bench reads the cycle count right after each accepting edge and puts the four expected rows in a queue, each stamped with its due cycle. It then compares `out_valid`, `out_row`, `out_pix` and `in_ready` against that queue on every falling edge. This way an early row, a late row or a stray strobe is reported in the cycle it happens.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
    // 13-bit fractional transform constants
    localparam int K_EVN_A = 15137;
    localparam int K_EVN_B = -6270;
    localparam int K_OA_1  = 20995;
    localparam int K_OA_3  = 7373;
    localparam int K_OA_5  = -4926;
    localparam int K_OA_7  = -4176;
    localparam int K_OB_1  = 8697;
    localparam int K_OB_3  = -17799;
    localparam int K_OB_5  = 11893;
    localparam int K_OB_7  = -1730;
    localparam int DC_SH   = 14;

    localparam int BLK_DIM = 8;   // coefficient block side
    localparam int SKIP    = 4;   // transform index never used
    localparam int TAPS    = BLK_DIM - 1;
    localparam int OUTS    = BLK_DIM / 2;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_COLS = 2'd1,
        PH_ROWS = 2'd2
    } phase_e;

    // map a line index (never SKIP) onto compressed storage 0..TAPS-1
    function automatic logic [2:0] squeeze_idx(input logic [2:0] k);
        return (k > 3'(SKIP)) ? k - 3'd1 : k;
    endfunction
endpackage

// File: rtl/idct4_lane.sv
module idct4_lane
    import idct4_pkg::*;
#(
    parameter int W     = 16,
    parameter int AW    = 32,
    parameter int SHIFT = 12
) (
    input  logic [TAPS-1:0][W-1:0] x_i,   // positions 0,1,2,3,5,6,7
    output logic [OUTS-1:0][W-1:0] y_o
);
    localparam logic signed [AW-1:0] RND = AW'(1) <<< (SHIFT - 1);

    logic signed [AW-1:0] v [TAPS];
    logic signed [AW-1:0] sum [OUTS];
    logic signed [AW-1:0] dc, ev_part, even_p, even_m, odd_a, odd_b;

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            v[k] = {{(AW-W){x_i[k][W-1]}}, x_i[k]};
        end
        dc      = v[0] <<< DC_SH;
        ev_part = v[2] * K_EVN_A + v[5] * K_EVN_B;
        even_p  = dc + ev_part;
        even_m  = dc - ev_part;
        odd_a   = v[1] * K_OA_1 + v[3] * K_OA_3 + v[4] * K_OA_5 + v[6] * K_OA_7;
        odd_b   = v[1] * K_OB_1 + v[3] * K_OB_3 + v[4] * K_OB_5 + v[6] * K_OB_7;
        sum[0]  = even_p + odd_a;
        sum[1]  = even_m + odd_b;
        sum[2]  = even_m - odd_b;
        sum[3]  = even_p - odd_a;
        for (int j = 0; j < OUTS; j++) begin
            y_o[j] = W'((sum[j] + RND) >>> SHIFT);
        end
    end
endmodule

// File: rtl/idct4_sat.sv
module idct4_sat #(
    parameter int W  = 16,
    parameter int PW = 8
) (
    input  logic [W-1:0]  v_i,
    output logic [PW-1:0] p_o
);
    localparam logic [W-1:0]        BIAS = W'(1) << (PW - 1);
    localparam logic signed [W-1:0] TOP  = W'((1 << PW) - 1);

    logic signed [W-1:0] t;

    always_comb begin
        t = v_i + BIAS;
        if (t < 0)        p_o = '0;
        else if (t > TOP) p_o = '1;
        else              p_o = t[PW-1:0];
    end
endmodule

// File: rtl/idct4_quarter.sv
module idct4_quarter
    import idct4_pkg::*;
#(
    parameter int CW     = 16,
    parameter int AW     = 32,
    parameter int PW     = 8,
    parameter int SH_COL = 12,
    parameter int SH_ROW = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CW-1:0]            in_coef,
    input  logic [CW-1:0]            in_qnt,
    output logic                     out_valid,
    output logic [$clog2(OUTS)-1:0]  out_row,
    output logic [OUTS*PW-1:0]       out_pix
);
    localparam int NBEAT = BLK_DIM * BLK_DIM;
    localparam int IW    = $clog2(NBEAT);
    localparam int DW    = $clog2(BLK_DIM);
    localparam int CIW   = $clog2(TAPS);
    localparam int RIW   = $clog2(OUTS);

    typedef struct packed {
        phase_e                         phase;
        logic [IW-1:0]                  beat;
        logic [CIW-1:0]                 col;
        logic [RIW-1:0]                 row;
        logic [TAPS-1:0][TAPS-1:0][CW-1:0] coef;
        logic [OUTS-1:0][TAPS-1:0][CW-1:0] work;
        logic                           ov;
        logic [RIW-1:0]                 orow;
        logic [OUTS-1:0][PW-1:0]        pix;
    } st_t;

    st_t s_d, s_q;

    logic [TAPS-1:0][CW-1:0] col_taps, row_taps;
    logic [OUTS-1:0][CW-1:0] col_res, row_res;
    logic [OUTS-1:0][PW-1:0] row_pix;
    logic [CW-1:0]           deq;
    logic [DW-1:0]           b_r, b_c;

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            col_taps[k] = s_q.coef[k][s_q.col];
        end
        row_taps = s_q.work[s_q.row];
    end

    idct4_lane #(.W(CW), .AW(AW), .SHIFT(SH_COL)) u_col (
        .x_i (col_taps),
        .y_o (col_res)
    );

    idct4_lane #(.W(CW), .AW(AW), .SHIFT(SH_ROW)) u_row (
        .x_i (row_taps),
        .y_o (row_res)
    );

    for (genvar g = 0; g < OUTS; g++) begin : g_sat
        idct4_sat #(.W(CW), .PW(PW)) u_sat (
            .v_i (row_res[g]),
            .p_o (row_pix[g])
        );
    end

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        deq    = in_coef * in_qnt;
        b_r    = s_q.beat[IW-1 -: DW];
        b_c    = s_q.beat[DW-1:0];
        unique case (s_q.phase)
            PH_LOAD: begin
                if (in_valid) begin
                    if (b_r != 3'(SKIP) && b_c != 3'(SKIP)) begin
                        s_d.coef[squeeze_idx(b_r)][squeeze_idx(b_c)] = deq;
                    end
                    s_d.beat = s_q.beat + 1'b1;
                    if (s_q.beat == IW'(NBEAT - 1)) begin
                        s_d.phase = PH_COLS;
                        s_d.col   = '0;
                    end
                end
            end
            PH_COLS: begin
                for (int r = 0; r < OUTS; r++) begin
                    s_d.work[r][s_q.col] = col_res[r];
                end
                if (s_q.col == CIW'(TAPS - 1)) begin
                    s_d.phase = PH_ROWS;
                    s_d.row   = '0;
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
            PH_ROWS: begin
                s_d.pix  = row_pix;
                s_d.ov   = 1'b1;
                s_d.orow = s_q.row;
                if (s_q.row == RIW'(OUTS - 1)) begin
                    s_d.phase = PH_LOAD;
                    s_d.beat  = '0;
                end else begin
                    s_d.row = s_q.row + 1'b1;
                end
            end
            default: s_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = (s_q.phase == PH_LOAD);
    assign out_valid = s_q.ov;
    assign out_row   = s_q.orow;
    assign out_pix   = s_q.pix;

    // R1: stored coefficients stay put while the block is not accepting
    p_hold_coef_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(s_q.coef));

    // R8: rows follow one another without gaps
    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row != RIW'(OUTS - 1)) |=>
        (out_valid && out_row == $past(out_row) + 1'b1));

    // R8: a burst of rows starts at row 0
    p_first_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_row == '0));

    // R9: no beat accepted while earlier rows are still pending
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row != RIW'(OUTS - 1)) |-> !in_ready);

    // R9: input reopens together with the last row
    p_last_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row == RIW'(OUTS - 1)) |-> in_ready);
endmodule

// File: tb/idct4_quarter_tb.sv
module idct4_quarter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_coef = '0;
    logic [15:0] in_qnt = '0;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_row;
    logic [31:0] out_pix;

    idct4_quarter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_coef   (in_coef),
        .in_qnt    (in_qnt),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_pix   (out_pix)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          row;
        logic [31:0] pix;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // behavioural model --------------------------------------------------
    function automatic void line4(input int x[8], input int sh, output int y[4]);
        int ev, ep, em, oa, ob;
        int s[4];
        ev = 15137 * x[2] - 6270 * x[6];
        ep = 16384 * x[0] + ev;
        em = 16384 * x[0] - ev;
        oa = 20995 * x[1] + 7373 * x[3] - 4926 * x[5] - 4176 * x[7];
        ob = 8697 * x[1] - 17799 * x[3] + 11893 * x[5] - 1730 * x[7];
        s[0] = ep + oa;
        s[1] = em + ob;
        s[2] = em - ob;
        s[3] = ep - oa;
        for (int j = 0; j < 4; j++) begin
            y[j] = int'(shortint'((s[j] + (1 << (sh - 1))) >>> sh));
        end
    endfunction

    function automatic void model(input shortint c[64], input shortint q[64],
                                  output logic [31:0] rows[4]);
        int deq[8][8];
        int w[4][8];
        int x[8];
        int y[4];
        for (int i = 0; i < 64; i++) begin
            deq[i / 8][i % 8] = int'(shortint'(int'(c[i]) * int'(q[i])));
        end
        for (int col = 0; col < 8; col++) begin
            for (int r = 0; r < 8; r++) x[r] = (r == 4) ? 0 : deq[r][col];
            line4(x, 12, y);
            for (int r = 0; r < 4; r++) w[r][col] = y[r];
        end
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 8; k++) x[k] = (k == 4) ? 0 : w[r][k];
            line4(x, 19, y);
            rows[r] = '0;
            for (int j = 0; j < 4; j++) begin
                int t;
                t = int'(shortint'(y[j] + 128));
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                rows[r][8*j +: 8] = 8'(t);
            end
        end
    endfunction

    // every-cycle comparison (R8, R9) ------------------------------------
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_ready;
            if (expq.size() > 0 && expq[0].due == cyc) begin
                exp_ready = (expq.size() == 1);
                chk(out_valid == 1'b1, "R8", "row strobe", longint'(out_valid), 1);
                chk(int'(out_row) == expq[0].row, "R8", "row index",
                    longint'(out_row), longint'(expq[0].row));
                chk(out_pix == expq[0].pix, expq[0].tag, "pixels",
                    longint'(out_pix), longint'(expq[0].pix));
                void'(expq.pop_front());
            end else begin
                exp_ready = (expq.size() == 0);
                chk(out_valid == 1'b0, "R8", "stray strobe", longint'(out_valid), 0);
            end
            chk(in_ready == exp_ready, "R9", "in_ready", longint'(in_ready),
                longint'(exp_ready));
        end
    end

    // driver ---------------------------------------------------------------
    task automatic send_block(input shortint c[64], input shortint q[64],
                              input string tag, input bit junk, input bit gaps);
        logic [31:0] rows[4];
        model(c, q, rows);
        for (int b = 0; b < 64; b++) begin
            @(negedge clk);
            while (!in_ready) begin
                in_valid = junk;
                in_coef  = 16'($urandom);
                in_qnt   = 16'($urandom);
                @(negedge clk);
            end
            if (gaps && ($urandom_range(0, 3) == 0)) begin
                in_valid = 1'b0;
                in_coef  = 16'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_coef  = c[b];
            in_qnt   = q[b];
            @(posedge clk);
            #1;
            if (b == 63) begin
                for (int r = 0; r < 4; r++) begin
                    exp_t e;
                    e.due = cyc + 8 + r;
                    e.row = r;
                    e.pix = rows[r];
                    e.tag = tag;
                    expq.push_back(e);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic dc_block(input shortint dc, input string tag);
        shortint c[64];
        shortint q[64];
        for (int i = 0; i < 64; i++) begin c[i] = 0; q[i] = 1; end
        c[0] = dc;
        send_block(c, q, tag, 1'b0, 1'b0);
    endtask

    task automatic single_block(input int pos, input shortint val, input string tag);
        shortint c[64];
        shortint q[64];
        for (int i = 0; i < 64; i++) begin c[i] = 0; q[i] = 1; end
        c[pos] = val;
        send_block(c, q, tag, 1'b0, 1'b0);
    endtask

    task automatic rand_block(input int span, input bit noise4, input string tag,
                              input bit junk, input bit gaps);
        shortint c[64];
        shortint q[64];
        for (int i = 0; i < 64; i++) begin
            c[i] = shortint'(int'($urandom_range(0, 2 * span)) - span);
            q[i] = shortint'($urandom_range(1, 8));
            if (noise4 && (i / 8 == 4 || i % 8 == 4)) begin
                c[i] = shortint'($urandom);
                q[i] = shortint'($urandom);
            end
        end
        send_block(c, q, tag, junk, gaps);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R1", "reset in_ready", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "reset out_valid", longint'(out_valid), 0);

        dc_block(16'sd4,     "R5 round-up tie");
        dc_block(16'sd3,     "R5 round-down");
        dc_block(-16'sd5,    "R5 negative rounding");
        dc_block(16'sd2000,  "R7 clamp high");
        dc_block(-16'sd2000, "R7 clamp low");
        dc_block(16'sd0,     "R7 mid level");

        begin
            shortint c[64];
            shortint q[64];
            for (int i = 0; i < 64; i++) begin
                c[i] = (i / 8 == 4 || i % 8 == 4) ? 16'sh7abc : 16'sd0;
                q[i] = 16'sd37;
            end
            send_block(c, q, "R3 index-4 only", 1'b0, 1'b0);
        end

        single_block(8,  16'sd160, "R4 column odd term");
        single_block(16, -16'sd120, "R4 column even term");
        single_block(1,  16'sd160, "R6 row order odd");
        single_block(3,  -16'sd90, "R6 row order second odd");
        single_block(7,  16'sd200, "R6 row order last tap");

        begin
            shortint c[64];
            shortint q[64];
            for (int i = 0; i < 64; i++) begin c[i] = 0; q[i] = 1; end
            c[0] = 16'sd300;  q[0] = 16'sd300;
            c[9] = -16'sd700; q[9] = 16'sd150;
            send_block(c, q, "R2 product wrap", 1'b0, 1'b0);
        end

        for (int n = 0; n < 6; n++) rand_block(40, 1'b0, "R4 R5 R6 random", 1'b0, 1'b0);
        for (int n = 0; n < 6; n++) rand_block(40, 1'b1, "R3 random with index-4 noise", 1'b0, 1'b1);
        for (int n = 0; n < 6; n++) rand_block(120, 1'b0, "R1 junk while busy", 1'b1, 1'b1);
        for (int n = 0; n < 4; n++) rand_block(400, 1'b1, "R7 wide random", 1'b1, 1'b0);

        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R8", "rows outstanding", longint'(expq.size()), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule